// File: doc/BRIEF.md
# Two-Dimensional Byte Rectangle Mover

This engine copies a rectangle of bytes between two regions of a memory organised as 32-bit words. Software-side logic first issues a setup command that latches the source stride, the destination stride and the row count. It then issues a move command that carries the source address, the destination address, the row width and a transparency mode. The engine walks the rectangle row by row and handles it in chunks. A chunk is the part of a row that falls inside one destination word. For each chunk the engine reads the two source words that can hold its bytes and rotates the bytes into the destination lanes. It then writes the destination word with a byte-enable mask.

The transparency mode decides per byte whether a source byte reaches memory. The engine can copy every byte, only the non-zero bytes, or only the zero bytes. A masked byte keeps its old value in memory. The source and destination addresses may start on any byte, and each row may start on a different byte alignment because the strides are arbitrary byte counts. A one-cycle done pulse ends every move. Busy is high for the whole operation.

Top module: `bm2d_move`

## Requirements
- R1: A setup command (`setup_i` high while idle) latches the source stride, the destination stride and the row count, and later moves use them. When setup and move arrive in the same idle cycle, that move already uses the new values.
- R2: A move copies `width_i` bytes per row for the latched row count. Row r reads from source address + r × source stride and writes to destination address + r × destination stride. All addresses are byte addresses modulo 2^AW.
- R3: Mode 0 (and mode 3) writes every source byte of the rectangle to its destination byte.
- R4: Mode 1 writes only the non-zero source bytes. A destination byte whose source byte is zero keeps its previous value.
- R5: Mode 2 writes only the zero source bytes. All other destination bytes keep their previous value.
- R6: Results are correct for every combination of source and destination byte offset (0 to 3) and for zeros in every byte lane. No byte outside the destination rectangle changes.
- R7: A move with zero width or zero rows raises done in the cycle after the command and issues no memory write.
- R8: Busy is high from the cycle after an accepted move command through the cycle of the done pulse and low in the cycle after. Done lasts one cycle. Setup and move commands that arrive while busy are ignored.
- R9: The memory port uses word addresses, and read data returns one cycle after a read request. A write is issued only with at least one byte enable set, and no request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 1 | Setup command strobe |
| src_stride_i | input | AW | Source row stride in bytes |
| dst_stride_i | input | AW | Destination row stride in bytes |
| rows_i | input | RW | Number of rows |
| start_i | input | 1 | Move command strobe |
| src_addr_i | input | AW | Source start byte address |
| dst_addr_i | input | AW | Destination start byte address |
| width_i | input | WW | Row width in bytes |
| mode_i | input | 2 | Transparency mode: 0 all, 1 non-zero only, 2 zero only, 3 all |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle end-of-move pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | AW-2 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |

## Verification
Setup and move can land in the same cycle. The bench provokes this by raising both strobes on one idle edge with new strides and a new row count. It judges the result by comparing the whole memory image against a model that applied the new values, so a move that used the stale values leaves mismatching bytes. The bench also drives a second setup and a second move in the middle of a busy operation. It then checks that the memory image and a later setup-free move both follow the original parameters.

// File: rtl/bm2d_pkg.sv
package bm2d_pkg;
  typedef enum logic [1:0] {
    XM_ALL     = 2'd0,
    XM_NONZERO = 2'd1,
    XM_ZERO    = 2'd2,
    XM_ALL_ALT = 2'd3
  } xmode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD0,
    S_RD1,
    S_WR,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/bm2d_cfg.sv
module bm2d_cfg #(
  parameter int AW = 16,
  parameter int RW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          setup_i,
  input  logic [AW-1:0] src_stride_i,
  input  logic [AW-1:0] dst_stride_i,
  input  logic [RW-1:0] rows_i,
  output logic [AW-1:0] src_stride_o,
  output logic [AW-1:0] dst_stride_o,
  output logic [RW-1:0] rows_eff_o
);
  logic          take;
  logic [RW-1:0] rows_q;

  assign take = setup_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_stride_o <= '0;
      dst_stride_o <= '0;
      rows_q       <= '0;
    end else if (take) begin
      src_stride_o <= src_stride_i;
      dst_stride_o <= dst_stride_i;
      rows_q       <= rows_i;
    end
  end

  // same-cycle setup feeds the move that starts with it
  assign rows_eff_o = take ? rows_i : rows_q;
endmodule

// File: rtl/bm2d_align.sv
module bm2d_align
  import bm2d_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB),
  localparam int CW = OW + 1
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [OW-1:0] src_off_i,
  input  logic [OW-1:0] dst_off_i,
  input  logic [CW-1:0] cnt_i,
  input  xmode_e        mode_i,
  output logic [DW-1:0] wdata_o,
  output logic [NB-1:0] be_o
);
  logic [2*DW-1:0] win;
  logic [CW:0]     lane_end;

  assign win      = {hi_i, lo_i};
  assign lane_end = {2'b00, dst_off_i} + {1'b0, cnt_i};

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic [OW:0] sel;
    logic [7:0]  byte_v;
    logic        lane_on;
    logic        keep;

    always_comb begin
      sel     = (OW+1)'(k) + {1'b0, src_off_i} - {1'b0, dst_off_i};
      byte_v  = win[sel*8 +: 8];
      lane_on = ((CW+1)'(k) >= {2'b00, dst_off_i}) && ((CW+1)'(k) < lane_end);
      unique case (mode_i)
        XM_NONZERO: keep = (byte_v != 8'h00);
        XM_ZERO:    keep = (byte_v == 8'h00);
        default:    keep = 1'b1;
      endcase
    end

    assign wdata_o[k*8 +: 8] = byte_v;
    assign be_o[k]           = lane_on && keep;
  end
endmodule

// File: rtl/bm2d_seq.sv
module bm2d_seq
  import bm2d_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 12,
  parameter int RW = 10,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB),
  localparam int CW = OW + 1,
  localparam int WA = AW - OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [WW-1:0] width_i,
  input  xmode_e        mode_i,
  input  logic [RW-1:0] rows_i,
  input  logic [AW-1:0] src_stride_i,
  input  logic [AW-1:0] dst_stride_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [NB-1:0] be_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [WA-1:0] mem_addr_o,
  output logic [DW-1:0] lo_o,
  output logic [OW-1:0] src_off_o,
  output logic [OW-1:0] dst_off_o,
  output logic [CW-1:0] cnt_o,
  output xmode_e        mode_o
);
  seq_state_e    state_q;
  logic [AW-1:0] sp_q, dp_q, rs_q, rd_q;
  logic [WW-1:0] rem_q, width_q;
  logic [RW-1:0] rows_left_q;
  logic [CW-1:0] room, cnt;
  logic          last_chunk;

  assign room       = CW'(NB) - {1'b0, dp_q[OW-1:0]};
  assign cnt        = (rem_q < WW'(room)) ? rem_q[CW-1:0] : room;
  assign last_chunk = (rem_q == WW'(cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      sp_q        <= '0;
      dp_q        <= '0;
      rs_q        <= '0;
      rd_q        <= '0;
      rem_q       <= '0;
      width_q     <= '0;
      rows_left_q <= '0;
      mode_o      <= XM_ALL;
      lo_o        <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_o      <= mode_i;
          width_q     <= width_i;
          rem_q       <= width_i;
          rows_left_q <= rows_i;
          sp_q        <= src_addr_i;
          rs_q        <= src_addr_i;
          dp_q        <= dst_addr_i;
          rd_q        <= dst_addr_i;
          state_q     <= (width_i == '0 || rows_i == '0) ? S_FIN : S_RD0;
        end
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          lo_o    <= mem_rdata_i;
          state_q <= S_WR;
        end
        S_WR: begin
          if (last_chunk) begin
            if (rows_left_q == RW'(1)) begin
              state_q <= S_FIN;
            end else begin
              rows_left_q <= rows_left_q - RW'(1);
              rs_q        <= rs_q + src_stride_i;
              rd_q        <= rd_q + dst_stride_i;
              sp_q        <= rs_q + src_stride_i;
              dp_q        <= rd_q + dst_stride_i;
              rem_q       <= width_q;
              state_q     <= S_RD0;
            end
          end else begin
            sp_q    <= sp_q + AW'(cnt);
            dp_q    <= dp_q + AW'(cnt);
            rem_q   <= rem_q - WW'(cnt);
            state_q <= S_RD0;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = sp_q[AW-1:OW];
    unique case (state_q)
      S_RD0: mem_req_o = 1'b1;
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = sp_q[AW-1:OW] + WA'(1);
      end
      S_WR: begin
        mem_req_o  = |be_i;
        mem_we_o   = 1'b1;
        mem_addr_o = dp_q[AW-1:OW];
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_FIN);
  assign src_off_o = sp_q[OW-1:0];
  assign dst_off_o = dp_q[OW-1:0];
  assign cnt_o     = cnt;
endmodule

// File: rtl/bm2d_move.sv
module bm2d_move
  import bm2d_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 12,
  parameter int RW = 10,
  localparam int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB),
  localparam int CW = OW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_i,
  input  logic [AW-1:0]    src_stride_i,
  input  logic [AW-1:0]    dst_stride_i,
  input  logic [RW-1:0]    rows_i,
  input  logic             start_i,
  input  logic [AW-1:0]    src_addr_i,
  input  logic [AW-1:0]    dst_addr_i,
  input  logic [WW-1:0]    width_i,
  input  logic [1:0]       mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-OW-1:0] mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [NB-1:0]    mem_be_o,
  input  logic [DW-1:0]    mem_rdata_i
);
  logic [AW-1:0] ss, ds;
  logic [RW-1:0] rows_eff;
  logic [DW-1:0] lo_word;
  logic [OW-1:0] src_off, dst_off;
  logic [CW-1:0] cnt;
  xmode_e        mode_q;
  logic [NB-1:0] be;

  bm2d_cfg #(.AW(AW), .RW(RW)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_o),
    .setup_i      (setup_i),
    .src_stride_i (src_stride_i),
    .dst_stride_i (dst_stride_i),
    .rows_i       (rows_i),
    .src_stride_o (ss),
    .dst_stride_o (ds),
    .rows_eff_o   (rows_eff)
  );

  bm2d_seq #(.AW(AW), .WW(WW), .RW(RW), .DW(DW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .src_addr_i   (src_addr_i),
    .dst_addr_i   (dst_addr_i),
    .width_i      (width_i),
    .mode_i       (xmode_e'(mode_i)),
    .rows_i       (rows_eff),
    .src_stride_i (ss),
    .dst_stride_i (ds),
    .mem_rdata_i  (mem_rdata_i),
    .be_i         (be),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .lo_o         (lo_word),
    .src_off_o    (src_off),
    .dst_off_o    (dst_off),
    .cnt_o        (cnt),
    .mode_o       (mode_q)
  );

  // hi word is the read still on the bus during the write cycle
  bm2d_align #(.DW(DW)) u_align (
    .lo_i      (lo_word),
    .hi_i      (mem_rdata_i),
    .src_off_i (src_off),
    .dst_off_i (dst_off),
    .cnt_i     (cnt),
    .mode_i    (mode_q),
    .wdata_o   (mem_wdata_o),
    .be_o      (be)
  );

  assign mem_be_o = be;
endmodule

// File: rtl/bm2d_props.sv
module bm2d_props #(
  parameter int WW = 12,
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [WW-1:0] width_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [NB-1:0] mem_be_o
);
  assert_busy_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_inside_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_busy_ends_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

  assert_empty_move_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (width_i == '0) |=> done_o);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_write_has_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> (mem_be_o != '0));
endmodule

bind bm2d_move bm2d_props #(.WW(WW), .NB(NB)) u_props (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .width_i   (width_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_be_o  (mem_be_o)
);

// File: tb/sim_bm2d_move.sv
`timescale 1ns/1ps
module sim_bm2d_move;
  localparam int AW = 10;
  localparam int WW = 6;
  localparam int RW = 4;
  localparam int NBYTES = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          setup_i = 1'b0, start_i = 1'b0;
  logic [AW-1:0] src_stride_i = '0, dst_stride_i = '0, src_addr_i = '0, dst_addr_i = '0;
  logic [RW-1:0] rows_i = '0;
  logic [WW-1:0] width_i = '0;
  logic [1:0]    mode_i = '0;
  logic          busy_o, done_o, mem_req_o, mem_we_o;
  logic [AW-3:0] mem_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i;
  logic [3:0]    mem_be_o;

  bm2d_move #(.AW(AW), .WW(WW), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .setup_i(setup_i), .src_stride_i(src_stride_i),
    .dst_stride_i(dst_stride_i), .rows_i(rows_i), .start_i(start_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .width_i(width_i),
    .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int a, int seed);
    int h;
    if (a < NBYTES / 2) begin
      h = a * 29 + seed * 11 + 5;
      if ((h % 4) == 0) return 8'h00;
      return 8'(h);
    end
    return 8'((a * 13 + seed) | 1);
  endfunction

  // memory model: one-cycle read latency, bulk fill on request
  logic [31:0] mem [NBYTES/4];
  logic        fill_go = 1'b0;
  int          fill_seed = 0;
  int          wr_cnt = 0;
  always @(posedge clk) begin
    if (fill_go) begin
      for (int a = 0; a < NBYTES; a++) mem[a/4][(a%4)*8 +: 8] <= pat(a, fill_seed);
    end else if (mem_req_o) begin
      if (mem_we_o) begin
        wr_cnt <= wr_cnt + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
      end else begin
        mem_rdata_i <= mem[mem_addr_o];
      end
    end
  end

  logic [7:0] refm [NBYTES];
  int n_chk = 0, n_fail = 0;
  int cur_ss = 0, cur_ds = 0, cur_rows = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    @(negedge clk);
    fill_seed = seed;
    fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
    for (int a = 0; a < NBYTES; a++) refm[a] = pat(a, seed);
  endtask

  task automatic ref_move(input int src, dst, w, rows, ss, ds, mode);
    for (int r = 0; r < rows; r++)
      for (int i = 0; i < w; i++) begin
        int s, d;
        logic [7:0] b;
        s = (src + r * ss + i) % NBYTES;
        d = (dst + r * ds + i) % NBYTES;
        b = refm[s];
        if (mode == 1 ? (b != 0) : mode == 2 ? (b == 0) : 1'b1) refm[d] = b;
      end
  endtask

  task automatic compare(input string req);
    int bad = 0, first = -1;
    for (int a = 0; a < NBYTES; a++)
      if (mem[a/4][(a%4)*8 +: 8] !== refm[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    check(bad == 0, req, "mismatching bytes", bad, 0);
    if (first >= 0)
      $display("  first bad byte %0d: actual %0d expected %0d", first, mem[first/4][(first%4)*8 +: 8], refm[first]);
  endtask

  task automatic setup(input int ss, ds, rows);
    @(negedge clk);
    setup_i = 1'b1; src_stride_i = AW'(ss); dst_stride_i = AW'(ds); rows_i = RW'(rows);
    @(negedge clk);
    setup_i = 1'b0;
    cur_ss = ss; cur_ds = ds; cur_rows = rows;
  endtask

  // issues a move (optionally with setup in the same cycle) and waits for done
  task automatic run_move(input bit with_setup, input int ss, ds, rows, input int src, dst, w, mode);
    int t = 0;
    @(negedge clk);
    if (with_setup) begin
      setup_i = 1'b1; src_stride_i = AW'(ss); dst_stride_i = AW'(ds); rows_i = RW'(rows);
      cur_ss = ss; cur_ds = ds; cur_rows = rows;
    end
    start_i = 1'b1; src_addr_i = AW'(src); dst_addr_i = AW'(dst);
    width_i = WW'(w); mode_i = 2'(mode);
    @(negedge clk);
    start_i = 1'b0; setup_i = 1'b0;
    if (w == 0 || cur_rows == 0) begin
      check(done_o == 1'b1, "R7", "done one cycle after empty move", int'(done_o), 1);
    end else begin
      check(busy_o == 1'b1 && done_o == 1'b0, "R8", "busy without done after start",
            int'({busy_o, done_o}), 2);
      while (!done_o && t < 4000) begin
        @(negedge clk);
        t++;
      end
      check(t < 4000, "R8", "done reached", t, 0);
    end
    @(negedge clk);
    check(busy_o == 1'b0, "R8", "busy low after done", int'(busy_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed = 1;
    int w0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R8", "busy in reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R8", "done in reset", int'(done_o), 0);
    check(mem_req_o == 1'b0, "R9", "request in reset", int'(mem_req_o), 0);
    rst_ni = 1'b1;

    // R3 R4 R5 R6 R2: sweep mode x source offset x destination offset x width
    for (int mode = 0; mode < 3; mode++)
      for (int so = 0; so < 4; so++)
        for (int dof = 0; dof < 4; dof++)
          for (int wi = 0; wi < 3; wi++) begin
            int w, ss, ds, src, dst;
            w = (wi == 0) ? 1 : (wi == 1) ? 3 : 6;
            ss = 9 + so; ds = 7 + 2 * dof;
            src = 16 + so; dst = NBYTES / 2 + 8 + dof;
            fill(seed);
            setup(ss, ds, 3);
            ref_move(src, dst, w, 3, ss, ds, mode);
            run_move(1'b0, 0, 0, 0, src, dst, w, mode);
            compare(mode == 0 ? "R3 R6" : mode == 1 ? "R4 R6" : "R5 R6");
            seed++;
          end

    // R2: wide rectangle with mode 3
    fill(seed++);
    setup(27, 31, 5);
    ref_move(5, NBYTES / 2 + 2, 22, 5, 27, 31, 3);
    run_move(1'b0, 0, 0, 0, 5, NBYTES / 2 + 2, 22, 3);
    compare("R2 R3");

    // R7: zero rows, then zero width
    fill(seed++);
    setup(4, 4, 0);
    w0 = wr_cnt;
    run_move(1'b0, 0, 0, 0, 8, NBYTES / 2, 5, 0);
    check(wr_cnt == w0, "R7", "writes for zero rows", wr_cnt - w0, 0);
    setup(4, 4, 2);
    w0 = wr_cnt;
    run_move(1'b0, 0, 0, 0, 8, NBYTES / 2, 0, 0);
    check(wr_cnt == w0, "R7", "writes for zero width", wr_cnt - w0, 0);
    compare("R7");

    // R1: setup and move in the same idle cycle
    fill(seed++);
    setup(13, 9, 3);
    ref_move(21, NBYTES / 2 + 33, 7, 2, 5, 6, 0);
    run_move(1'b1, 5, 6, 2, 21, NBYTES / 2 + 33, 7, 0);
    compare("R1");

    // R8 R1: commands during a busy move are ignored
    fill(seed++);
    setup(13, 9, 3);
    ref_move(30, NBYTES / 2 + 1, 9, 3, 13, 9, 1);
    @(negedge clk);
    start_i = 1'b1; src_addr_i = AW'(30); dst_addr_i = AW'(NBYTES / 2 + 1);
    width_i = WW'(9); mode_i = 2'd1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    setup_i = 1'b1; start_i = 1'b1; src_stride_i = AW'(1); dst_stride_i = AW'(1);
    rows_i = RW'(1); src_addr_i = AW'(100); dst_addr_i = AW'(NBYTES - 40); mode_i = 2'd0;
    @(negedge clk);
    setup_i = 1'b0; start_i = 1'b0;
    begin
      int t = 0;
      while (!done_o && t < 4000) begin
        @(negedge clk);
        t++;
      end
      check(t < 4000, "R8", "done reached after stray commands", t, 0);
    end
    @(negedge clk);
    check(busy_o == 1'b0, "R8", "stray start not accepted", int'(busy_o), 0);
    compare("R8");
    ref_move(40, NBYTES / 2 + 100, 5, 3, 13, 9, 2);
    run_move(1'b0, 0, 0, 0, 40, NBYTES / 2 + 100, 5, 2);
    compare("R1 setup while busy ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule